// File: doc/BRIEF.md
# AES Channel Status Capture

This block watches a stream of 32-bit AES3-style subframes and rebuilds the 192-bit channel status block from the status bit that each frame of channel 0 carries. Frames from other channels are ignored. Assembly begins at a frame whose preamble field marks the start of a block. Once all 192 bits of that block have arrived, the block replaces the held copy. Software then reads the held copy as six 32-bit words through a word select.

A sticky update flag tells software that a new or changed block has been captured. The flag clears when it is read. A separate clear strobe wipes all six held words at once. Capture does not depend on any run control: it runs whenever frames arrive. Only the hard reset or the synchronous soft reset returns it to idle.

Top module: `aes_cs_capture`

## Requirements
- R1: A beat contributes only when `sValid` is high and `sId` is 0. Beats with any other ID, and cycles with `sValid` low, have no effect. This holds even when such a beat carries the block-start code. `sReady` is always 1.
- R2: The channel status bit is bit 30 of `sData`. The block-start beat supplies block bit 0, and the k-th accepted channel-0 beat after it supplies block bit k.
- R3: A channel-0 beat with `sData[3:0] == 4'h1` starts a new block. Beats that arrive before the first start, and beats that arrive after a block has completed, are ignored until the next start.
- R4: When the 192nd bit of a block is accepted, the held block is replaced, and the new value is readable in the next cycle. With `rdSel` = j (0 to 5), `rdData` returns block bits 32j+31 down to 32j. With `rdSel` = 6 or 7, `rdData` returns 0.
- R5: `updFlag` is set on a completed block when no block is held (after reset, soft reset or a word clear), or when the new block differs from the held one. A completed block equal to the held one leaves the flag as it was. Otherwise the flag holds its value until it is cleared.
- R6: A `flagRdStb` pulse clears `updFlag` in the next cycle. If a set event happens in the same cycle, the set wins.
- R7: A `wordClrStb` pulse sets all six held words to 0 and marks that no block is held. `updFlag` is not affected. A block that completes in the same cycle wins over the clear.
- R8: A start code that arrives before 192 bits have been collected discards the partial block. The held words stay unchanged.
- R9: `softRst`, sampled at a clock edge, clears the held words, the flag and the collection state, in the same way as `rstN`.
- R10: After reset, all six words read 0 and `updFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| softRst | input | 1 | Synchronous soft reset, active high |
| sValid | input | 1 | Stream beat valid |
| sReady | output | 1 | Stream ready, tied high |
| sData | input | 32 | Subframe: bit 30 is the status bit, bits 3:0 are the preamble code |
| sId | input | 3 | Channel number of the beat |
| flagRdStb | input | 1 | Read of the update flag, which clears it |
| wordClrStb | input | 1 | Write to any status word, which clears all six |
| rdSel | input | 3 | Selects the status word to read |
| rdData | output | 32 | Selected status word |
| updFlag | output | 1 | Sticky update flag |

## Verification
A wrong bit index or a wrong start detect puts the captured bits into the wrong positions, and this shows in the selected word in the cycle after the 192nd beat. A collection state that fails to stop after completion, or that wraps around, commits a second block during the trailing beats. That second commit changes the words or raises the flag within one block length. Errors in the held-valid marker or the compare show only when the same block is sent twice, or sent once after a clear. For that reason the flag is read after every block.

// File: rtl/aes_cs_pkg.sv
package aes_cs_pkg;
  localparam int CS_IDX_W = 8;

  typedef struct packed {
    logic                wrBit;
    logic                csBit;
    logic [CS_IDX_W-1:0] bitPos;
    logic                commit;
  } capStrobe_t;
endpackage

// File: rtl/aes_cs_ctrl.sv
module aes_cs_ctrl
  import aes_cs_pkg::*;
#(
  parameter int          BLK_BITS   = 192,
  parameter int          ID_W       = 3,
  parameter int          PRE_W      = 4,
  parameter logic [3:0]  START_CODE = 4'h1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             sValid,
  input  logic [ID_W-1:0]  sId,
  input  logic             csBitIn,
  input  logic [PRE_W-1:0] preIn,
  output capStrobe_t       strb
);
  localparam logic [CS_IDX_W-1:0] LAST_IDX = CS_IDX_W'(BLK_BITS - 1);

  logic                collecting;
  logic [CS_IDX_W-1:0] bitIdx;
  logic                beatOk;
  logic                isStart;

  assign beatOk  = sValid && (sId == '0);
  assign isStart = beatOk && (preIn == START_CODE[PRE_W-1:0]);

  always_comb begin
    strb.wrBit  = isStart || (beatOk && collecting);
    strb.csBit  = csBitIn;
    strb.bitPos = isStart ? '0 : bitIdx;
    strb.commit = strb.wrBit && (strb.bitPos == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collecting <= 1'b0;
      bitIdx     <= '0;
    end else if (softRst) begin
      collecting <= 1'b0;
      bitIdx     <= '0;
    end else if (strb.wrBit) begin
      if (strb.commit) begin
        collecting <= 1'b0;
        bitIdx     <= '0;
      end else begin
        collecting <= 1'b1;
        bitIdx     <= strb.bitPos + 1'b1;
      end
    end
  end

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    collecting |-> (bitIdx != '0 && bitIdx <= LAST_IDX));

  assert_foreign_id_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sValid && sId != '0) |-> !strb.wrBit);

  assert_commit_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !softRst) |=> !collecting);

  assert_start_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isStart && !softRst && BLK_BITS > 1) |=> (collecting && bitIdx == CS_IDX_W'(1)));
endmodule

// File: rtl/aes_cs_data.sv
module aes_cs_data
  import aes_cs_pkg::*;
#(
  parameter int BLK_BITS  = 192,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = BLK_BITS / WORD_W,
  parameter int SEL_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  capStrobe_t        strb,
  input  logic              flagRdStb,
  input  logic              wordClrStb,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [WORD_W-1:0] rdData,
  output logic              updFlag
);
  logic [BLK_BITS-1:0] asmReg;
  logic [BLK_BITS-1:0] asmNext;
  logic [BLK_BITS-1:0] heldReg;
  logic                heldValid;
  logic                setEvt;
  logic [WORD_W-1:0]   wordArr [NUM_WORDS];

  always_comb begin
    asmNext = asmReg;
    if (strb.wrBit) asmNext[strb.bitPos] = strb.csBit;
  end

  assign setEvt = strb.commit && (!heldValid || (asmNext != heldReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asmReg    <= '0;
      heldReg   <= '0;
      heldValid <= 1'b0;
      updFlag   <= 1'b0;
    end else if (softRst) begin
      asmReg    <= '0;
      heldReg   <= '0;
      heldValid <= 1'b0;
      updFlag   <= 1'b0;
    end else begin
      asmReg <= asmNext;
      if (strb.commit) begin
        heldReg   <= asmNext;
        heldValid <= 1'b1;
      end else if (wordClrStb) begin
        heldReg   <= '0;
        heldValid <= 1'b0;
      end
      if (setEvt)         updFlag <= 1'b1;
      else if (flagRdStb) updFlag <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign wordArr[g] = heldReg[g*WORD_W +: WORD_W];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rdSel == SEL_W'(i)) rdData = wordArr[i];
    end
  end

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !softRst && (!heldValid || asmNext != heldReg)) |=> updFlag);

  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updFlag) |-> $past(strb.commit));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagRdStb && !strb.commit && !softRst) |=> !updFlag);

  assert_word_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wordClrStb && !strb.commit) |=> (heldReg == '0 && !heldValid));

  assert_held_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !wordClrStb && !softRst) |=> $stable(heldReg));
endmodule

// File: rtl/aes_cs_capture.sv
module aes_cs_capture
  import aes_cs_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter int         ID_W       = 3,
  parameter int         BLK_BITS   = 192,
  parameter int         WORD_W     = 32,
  parameter int         SEL_W      = 3,
  parameter int         CS_BIT     = 30,
  parameter int         PRE_W      = 4,
  parameter logic [3:0] START_CODE = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  input  logic [ID_W-1:0]   sId,
  input  logic              flagRdStb,
  input  logic              wordClrStb,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [WORD_W-1:0] rdData,
  output logic              updFlag
);
  localparam int NUM_WORDS = BLK_BITS / WORD_W;

  capStrobe_t strb;
  logic       unusedBits;

  assign sReady     = 1'b1;
  assign unusedBits = ^{sData[DATA_W-1:CS_BIT+1], sData[CS_BIT-1:PRE_W]};

  aes_cs_ctrl #(
    .BLK_BITS(BLK_BITS), .ID_W(ID_W), .PRE_W(PRE_W), .START_CODE(START_CODE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .sValid(sValid), .sId(sId),
    .csBitIn(sData[CS_BIT]), .preIn(sData[PRE_W-1:0]), .strb(strb)
  );

  aes_cs_data #(
    .BLK_BITS(BLK_BITS), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .strb(strb),
    .flagRdStb(flagRdStb), .wordClrStb(wordClrStb), .rdSel(rdSel),
    .rdData(rdData), .updFlag(updFlag)
  );
endmodule

// File: tb/aes_cs_capture_tb_top.sv
`timescale 1ns/1ps
module aes_cs_capture_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic        sValid = 1'b0;
  logic        sReady;
  logic [31:0] sData = 32'h4000_0001;
  logic [2:0]  sId = 3'd0;
  logic        flagRdStb = 1'b0;
  logic        wordClrStb = 1'b0;
  logic [2:0]  rdSel = 3'd0;
  logic [31:0] rdData;
  logic        updFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aes_cs_capture dut_i (
    .clk(clk), .rstN(rstN), .softRst(softRst), .sValid(sValid), .sReady(sReady),
    .sData(sData), .sId(sId), .flagRdStb(flagRdStb), .wordClrStb(wordClrStb),
    .rdSel(rdSel), .rdData(rdData), .updFlag(updFlag)
  );

  // {seed[31:0], read flag before the block, expected flag after it}
  localparam logic [33:0] VEC [6] = '{
    {32'h1357_9BDF, 1'b0, 1'b1},
    {32'h1357_9BDF, 1'b1, 1'b0},
    {32'hA5C3_0F96, 1'b0, 1'b1},
    {32'hA5C3_0F96, 1'b1, 1'b0},
    {32'h0BAD_F00D, 1'b1, 1'b1},
    {32'h0BAD_F00D, 1'b0, 1'b1}
  };

  function automatic logic [191:0] pat(input logic [31:0] seed);
    logic [191:0] b;
    for (int j = 0; j < 6; j++)
      b[j*32 +: 32] = (seed * (j + 3)) ^ {seed[15:0], seed[31:16]} ^ (32'h0101_0101 * j);
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [2:0] id, input logic bitv, input logic [3:0] pre, input logic rd);
    @(negedge clk);
    sValid = 1'b1; sId = id; sData = {1'b0, bitv, 26'h155_5555, pre}; flagRdStb = rd;
    @(negedge clk);
    sValid = 1'b0; flagRdStb = 1'b0; sId = 3'd0; sData = 32'h4000_0001;
  endtask

  // R1 R2: channel-1 beats with inverted bits and the start code are interleaved
  task automatic sendBlock(input logic [31:0] seed, input int nBits, input logic rdLast);
    logic [191:0] b;
    b = pat(seed);
    for (int k = 0; k < nBits; k++) begin
      if (k % 3 == 0) beat(3'd1, ~b[k], 4'h1, 1'b0);
      beat(3'd0, b[k], (k == 0) ? 4'h1 : 4'h2, (k == nBits - 1) ? rdLast : 1'b0);
    end
  endtask

  task automatic sendRaw(input int n, input logic bitv);
    for (int k = 0; k < n; k++) beat(3'd0, bitv, 4'h2, 1'b0);
  endtask

  task automatic checkWords(input logic [191:0] exp, input string req);
    for (int j = 0; j < 6; j++) begin
      rdSel = 3'(j);
      #0.5;
      check(rdData == exp[j*32 +: 32], req, rdData, exp[j*32 +: 32]);
    end
  endtask

  task automatic readFlag();
    @(negedge clk); flagRdStb = 1'b1;
    @(negedge clk); flagRdStb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(sReady == 1'b1, "R10 ready", 32'(sReady), 32'd1);
    check(updFlag == 1'b0, "R10 flag", 32'(updFlag), 32'd0);
    checkWords(192'd0, "R10 words");

    // R3: beats before any start are ignored
    sendRaw(192, 1'b1);
    checkWords(192'd0, "R3 no start");
    check(updFlag == 1'b0, "R3 no start flag", 32'(updFlag), 32'd0);

    // Table walk: R2 R4 R5
    for (int i = 0; i < 6; i++) begin
      if (VEC[i][1]) readFlag();
      sendBlock(VEC[i][33:2], 192, 1'b0);
      check(updFlag == VEC[i][0], "R5 table flag", 32'(updFlag), 32'(VEC[i][0]));
      checkWords(pat(VEC[i][33:2]), "R2 R4 table words");
    end

    // R8: partial block discarded
    readFlag();
    sendBlock(32'hDEAD_0042, 100, 1'b0);
    checkWords(pat(32'h0BAD_F00D), "R8 partial held");
    check(updFlag == 1'b0, "R8 partial flag", 32'(updFlag), 32'd0);
    sendBlock(32'hDEAD_0042, 192, 1'b0);
    checkWords(pat(32'hDEAD_0042), "R8 restart words");
    check(updFlag == 1'b1, "R8 restart flag", 32'(updFlag), 32'd1);

    // R3: beats after completion ignored
    readFlag();
    sendRaw(200, 1'b0);
    checkWords(pat(32'hDEAD_0042), "R3 trailing words");
    check(updFlag == 1'b0, "R3 trailing flag", 32'(updFlag), 32'd0);

    // R7: word clear; flag untouched; same block then counts as new
    @(negedge clk); wordClrStb = 1'b1;
    @(negedge clk); wordClrStb = 1'b0;
    checkWords(192'd0, "R7 cleared words");
    check(updFlag == 1'b0, "R7 flag untouched", 32'(updFlag), 32'd0);
    sendBlock(32'hDEAD_0042, 192, 1'b0);
    check(updFlag == 1'b1, "R7 flag after clear", 32'(updFlag), 32'd1);
    checkWords(pat(32'hDEAD_0042), "R7 words after clear");

    // R6: set wins over read in the same cycle, then read clears
    readFlag();
    check(updFlag == 1'b0, "R6 read clears", 32'(updFlag), 32'd0);
    sendBlock(32'h7777_1234, 192, 1'b1);
    check(updFlag == 1'b1, "R6 set wins", 32'(updFlag), 32'd1);
    readFlag();
    check(updFlag == 1'b0, "R6 read clears again", 32'(updFlag), 32'd0);

    // R4: out-of-range selects
    rdSel = 3'd6; #0.5;
    check(rdData == 32'd0, "R4 sel6", rdData, 32'd0);
    rdSel = 3'd7; #0.5;
    check(rdData == 32'd0, "R4 sel7", rdData, 32'd0);

    // R9: soft reset
    sendBlock(32'h0F0F_5A5A, 192, 1'b0);
    check(updFlag == 1'b1, "R9 pre flag", 32'(updFlag), 32'd1);
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    check(updFlag == 1'b0, "R9 flag", 32'(updFlag), 32'd0);
    checkWords(192'd0, "R9 words");
    sendRaw(192, 1'b1);
    checkWords(192'd0, "R9 idle after soft reset");
    check(updFlag == 1'b0, "R9 idle flag", 32'(updFlag), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule